// File: doc/BRIEF.md
# Add-Immediate and Doubleword-Load Execution Unit

This block is a very small integer execution unit for a 64-bit machine. It takes one 32-bit instruction word at a time, decodes it, and executes two instructions: add-immediate and load-doubleword. It holds the 32 general registers, the program counter and the next-PC register. Any other word is flagged as illegal and changes no state.

An add-immediate finishes in the cycle it is accepted. A load sends one read request to memory and then waits for the eight-byte response. The unit stops accepting instructions until that response arrives. Every instruction that retires reports its destination register and result on a write-back port. This port also gives the only view of register contents.

Top module: `mini_exu`

## Requirements
- R1: A word with bits [6:0] = 0010011 and bits [14:12] = 000 is add-immediate. rs1 is bits [19:15], rd is bits [11:7] and the immediate is bits [31:20]. The unit writes rs1 + imm into rd and, one cycle after acceptance, pulses `wb_valid` with `wb_rd` = rd and `wb_data` = the sum.
- R2: The 12-bit immediate is sign-extended to 64 bits before use, so bit 31 set gives a negative offset (for example 0x800 is -2048).
- R3: A word with bits [6:0] = 0000011 and bits [14:12] = 011 is load-doubleword. One cycle after acceptance, `mem_req_valid` is high for exactly one cycle with `mem_req_addr` = rs1 + sign-extended imm.
- R4: From the acceptance of a load until the clock edge that samples `mem_rsp_valid` high, `instr_ready` is low. Words offered in that window are not executed and change no register.
- R5: The 64-bit `mem_rsp_data` is written to the load's rd. `wb_valid` pulses one cycle after the response is sampled, with that data.
- R6: Register 0 always reads as zero.
- R7: A write to register 0 is discarded. The write-back port still reports the result, but later reads of register 0 return zero.
- R8: Any other word, including a correct opcode with the wrong function field, pulses `illegal` for one cycle after acceptance. It changes no register and leaves `pc` unchanged. `illegal` and `wb_valid` are never high together.
- R9: On each retirement `pc` takes the next-PC value, which is always `pc` + 4, so `pc` rises by 4 per retired instruction and stays word-aligned.
- R10: Reset clears `pc` and every register. It leaves `instr_ready` high and `wb_valid`, `illegal` and `mem_req_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction word is offered |
| instr_word | input | 32 | Instruction word |
| instr_ready | output | 1 | The unit can accept a word (not busy) |
| mem_req_valid | output | 1 | Read request pulse |
| mem_req_addr | output | 64 | Read address |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 64 | Eight bytes of read data |
| wb_valid | output | 1 | An instruction retired |
| wb_rd | output | 5 | Destination register of the retired instruction |
| wb_data | output | 64 | Result of the retired instruction |
| illegal | output | 1 | An unsupported word was rejected |
| pc | output | 64 | Program counter |

## Verification
Add-immediate is exercised with positive, negative and extreme immediates (+2047, -1, -2048). These patterns separate correct sign extension from zero extension and from truncation. Loads use an address that is itself loaded data and a negative offset. A memory model returns data derived from the address, so a wrong address shows up as wrong data. Illegal words include correct opcodes with a neighbouring function field, all-zeros, all-ones and a store encoding. These tell exact two-field matching apart from opcode-only matching. Words offered during a load wait, and writes aimed at register 0, are each followed by a read of the affected register through a later add-immediate, which shows that neither changed any state.

// File: rtl/exu_pkg.sv
package exu_pkg;
    localparam int unsigned OPC_W = 7;
    localparam int unsigned FN3_W = 3;
    localparam logic [OPC_W-1:0] OPC_OPIMM = 7'b0010011;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 7'b0000011;
    localparam logic [FN3_W-1:0] FN3_ADD   = 3'b000;
    localparam logic [FN3_W-1:0] FN3_DWORD = 3'b011;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } exu_state_e;
endpackage

// File: rtl/exu_decode.sv
module exu_decode #(
    parameter int unsigned XLEN  = 64,
    parameter int unsigned ILEN  = 32,
    parameter int unsigned RIDX  = 5,
    parameter int unsigned IMM_W = 12
) (
    input  logic [ILEN-1:0] word,
    output logic            is_addi,
    output logic            is_load,
    output logic [RIDX-1:0] src_idx,
    output logic [RIDX-1:0] dst_idx,
    output logic [XLEN-1:0] imm_ext
);
    import exu_pkg::*;

    localparam int unsigned DST_LO = OPC_W;
    localparam int unsigned FN_LO  = DST_LO + RIDX;
    localparam int unsigned SRC_LO = FN_LO + FN3_W;
    localparam int unsigned IMM_LO = SRC_LO + RIDX;

    logic [OPC_W-1:0] opc;
    logic [FN3_W-1:0] fn3;
    logic [IMM_W-1:0] imm_raw;

    always_comb begin
        opc     = word[OPC_W-1:0];
        dst_idx = word[DST_LO +: RIDX];
        fn3     = word[FN_LO +: FN3_W];
        src_idx = word[SRC_LO +: RIDX];
        imm_raw = word[IMM_LO +: IMM_W];
        imm_ext = {{(XLEN-IMM_W){imm_raw[IMM_W-1]}}, imm_raw};
        is_addi = (opc == OPC_OPIMM) && (fn3 == FN3_ADD);
        is_load = (opc == OPC_LOAD)  && (fn3 == FN3_DWORD);
    end
endmodule

// File: rtl/exu_regfile.sv
module exu_regfile #(
    parameter int unsigned XLEN = 64,
    parameter int unsigned NREG = 32,
    localparam int unsigned AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   rd_idx,
    output logic [XLEN-1:0] rd_val,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_idx,
    input  logic [XLEN-1:0] wr_val
);
    logic [XLEN-1:0] cell_q [1:NREG-1];

    for (genvar g = 1; g < NREG; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_q[g] <= '0;
            end else if (wr_en && (wr_idx == AW'(g))) begin
                cell_q[g] <= wr_val;
            end
        end
    end

    always_comb begin
        if (rd_idx == '0) begin
            rd_val = '0;
        end else begin
            rd_val = cell_q[rd_idx];
        end
    end
endmodule

// File: rtl/mini_exu.sv
module mini_exu #(
    parameter int unsigned XLEN  = 64,
    parameter int unsigned ILEN  = 32,
    parameter int unsigned NREG  = 32,
    parameter int unsigned IMM_W = 12,
    localparam int unsigned RIDX = $clog2(NREG),
    localparam int unsigned STEP = ILEN / 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic [ILEN-1:0] instr_word,
    output logic            instr_ready,
    output logic            mem_req_valid,
    output logic [XLEN-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [XLEN-1:0] mem_rsp_data,
    output logic            wb_valid,
    output logic [RIDX-1:0] wb_rd,
    output logic [XLEN-1:0] wb_data,
    output logic            illegal,
    output logic [XLEN-1:0] pc
);
    import exu_pkg::*;

    typedef struct packed {
        exu_state_e      st;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] npc;
        logic [RIDX-1:0] ld_rd;
        logic            req;
        logic [XLEN-1:0] addr;
        logic            wb_v;
        logic [RIDX-1:0] wb_rd;
        logic [XLEN-1:0] wb_data;
        logic            ill;
    } exu_regs_t;

    exu_regs_t r_d, r_q;

    logic            dec_addi, dec_load;
    logic [RIDX-1:0] dec_src, dec_dst;
    logic [XLEN-1:0] dec_imm;
    logic [XLEN-1:0] src_val, sum_val;
    logic            rf_we;
    logic [RIDX-1:0] rf_wa;
    logic [XLEN-1:0] rf_wd;

    exu_decode #(.XLEN(XLEN), .ILEN(ILEN), .RIDX(RIDX), .IMM_W(IMM_W)) dec_i (
        .word    (instr_word),
        .is_addi (dec_addi),
        .is_load (dec_load),
        .src_idx (dec_src),
        .dst_idx (dec_dst),
        .imm_ext (dec_imm)
    );

    exu_regfile #(.XLEN(XLEN), .NREG(NREG)) rf_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (dec_src),
        .rd_val (src_val),
        .wr_en  (rf_we),
        .wr_idx (rf_wa),
        .wr_val (rf_wd)
    );

    assign sum_val = src_val + dec_imm;

    always_comb begin
        r_d    = r_q;
        r_d.req  = 1'b0;
        r_d.wb_v = 1'b0;
        r_d.ill  = 1'b0;
        rf_we  = 1'b0;
        rf_wa  = '0;
        rf_wd  = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (instr_valid) begin
                    if (dec_addi) begin
                        rf_we       = 1'b1;
                        rf_wa       = dec_dst;
                        rf_wd       = sum_val;
                        r_d.wb_v    = 1'b1;
                        r_d.wb_rd   = dec_dst;
                        r_d.wb_data = sum_val;
                        r_d.pc      = r_q.npc;
                        r_d.npc     = r_q.npc + XLEN'(STEP);
                    end else if (dec_load) begin
                        r_d.req   = 1'b1;
                        r_d.addr  = sum_val;
                        r_d.ld_rd = dec_dst;
                        r_d.st    = ST_WAIT;
                    end else begin
                        r_d.ill = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    rf_we       = 1'b1;
                    rf_wa       = r_q.ld_rd;
                    rf_wd       = mem_rsp_data;
                    r_d.wb_v    = 1'b1;
                    r_d.wb_rd   = r_q.ld_rd;
                    r_d.wb_data = mem_rsp_data;
                    r_d.pc      = r_q.npc;
                    r_d.npc     = r_q.npc + XLEN'(STEP);
                    r_d.st      = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.st      <= ST_IDLE;
            r_q.npc     <= XLEN'(STEP);
        end else begin
            r_q <= r_d;
        end
    end

    assign instr_ready   = (r_q.st == ST_IDLE);
    assign mem_req_valid = r_q.req;
    assign mem_req_addr  = r_q.addr;
    assign wb_valid      = r_q.wb_v;
    assign wb_rd         = r_q.wb_rd;
    assign wb_data       = r_q.wb_data;
    assign illegal       = r_q.ill;
    assign pc            = r_q.pc;
endmodule

// File: rtl/mini_exu_chk.sv
module mini_exu_chk #(
    parameter int unsigned XLEN = 64,
    parameter int unsigned RIDX = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            instr_valid,
    input logic            instr_ready,
    input logic            mem_req_valid,
    input logic            mem_rsp_valid,
    input logic            wb_valid,
    input logic [RIDX-1:0] wb_rd,
    input logic            illegal,
    input logic [XLEN-1:0] pc
);
    // R3: request lasts one cycle
    p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R4: unit is busy while its request is out
    p_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !instr_ready);

    // R4: a response while idle does not retire anything
    p_idle_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_ready && !instr_valid && mem_rsp_valid) |=> !wb_valid);

    // R8: rejection leaves pc alone
    p_illegal_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (pc == $past(pc)));

    // R8: rejection and retirement are exclusive
    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(illegal && wb_valid));

    // R9: pc steps by one word per retirement
    p_retire_pc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (pc == $past(pc) + XLEN'(4)));

    // R9: pc only moves on retirement
    p_pc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_valid |-> $stable(pc));

    // R9: pc stays word-aligned
    p_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pc[1:0] == 2'b00);
endmodule

bind mini_exu mini_exu_chk #(.XLEN(XLEN), .RIDX(RIDX)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_valid   (instr_valid),
    .instr_ready   (instr_ready),
    .mem_req_valid (mem_req_valid),
    .mem_rsp_valid (mem_rsp_valid),
    .wb_valid      (wb_valid),
    .wb_rd         (wb_rd),
    .illegal       (illegal),
    .pc            (pc)
);

// File: tb/mini_exu_tb_top.sv
module mini_exu_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  MEM_LAT    = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic        instr_ready;
    logic        mem_req_valid;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        wb_valid;
    logic [4:0]  wb_rd;
    logic [63:0] wb_data;
    logic        illegal;
    logic [63:0] pc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [63:0] model_reg [32];
    logic [63:0] model_pc;

    logic [4:0]  exp_rd_q   [$];
    logic [63:0] exp_data_q [$];
    logic [63:0] exp_pc_q   [$];
    string       exp_tag_q  [$];
    logic [63:0] exp_addr_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mini_exu dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .instr_valid   (instr_valid),
        .instr_word    (instr_word),
        .instr_ready   (instr_ready),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .wb_valid      (wb_valid),
        .wb_rd         (wb_rd),
        .wb_data       (wb_data),
        .illegal       (illegal),
        .pc            (pc)
    );

    function automatic logic [63:0] mem_f(input logic [63:0] a);
        return {~a[31:0], a[31:0]} ^ 64'h0123_4567_89AB_CDEF;
    endfunction

    function automatic logic [31:0] enc_addi(input int rd, input int rs1, input int imm);
        return {12'(imm), 5'(rs1), 3'b000, 5'(rd), 7'b0010011};
    endfunction

    function automatic logic [31:0] enc_ld(input int rd, input int rs1, input int imm);
        return {12'(imm), 5'(rs1), 3'b011, 5'(rd), 7'b0000011};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: predicts the result, queues it, then offers the word.
    task automatic issue(input logic [31:0] w, input string tag);
        logic [63:0] sx, sum, dat;
        int rd, rs1;
        bit is_addi, is_ld;
        rd  = int'(w[11:7]);
        rs1 = int'(w[19:15]);
        sx  = {{52{w[31]}}, w[31:20]};
        sum = model_reg[rs1] + sx;
        is_addi = (w[6:0] == 7'b0010011) && (w[14:12] == 3'b000);
        is_ld   = (w[6:0] == 7'b0000011) && (w[14:12] == 3'b011);
        if (is_addi || is_ld) begin
            dat = is_addi ? sum : mem_f(sum);
            if (is_ld) exp_addr_q.push_back(sum);
            if (rd != 0) model_reg[rd] = dat;
            model_pc = model_pc + 64'd4;
            exp_rd_q.push_back(5'(rd));
            exp_data_q.push_back(dat);
            exp_pc_q.push_back(model_pc);
            exp_tag_q.push_back(tag);
        end
        @(negedge clk);
        while (!instr_ready) @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = w;
        @(negedge clk);
        instr_valid = 1'b0;
        if (!(is_addi || is_ld)) begin
            check(illegal == 1'b1, {tag, " illegal flag"}, 64'(illegal), 64'd1);
            check(pc == model_pc, {tag, " pc held"}, pc, model_pc);
        end
    endtask

    // Monitor: compares each retirement against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && wb_valid) begin
            if (exp_rd_q.size() == 0) begin
                check(1'b0, "R8 unexpected retirement", wb_data, 64'd0);
            end else begin
                logic [4:0]  e_rd;
                logic [63:0] e_data, e_pc;
                string       e_tag;
                e_rd   = exp_rd_q.pop_front();
                e_data = exp_data_q.pop_front();
                e_pc   = exp_pc_q.pop_front();
                e_tag  = exp_tag_q.pop_front();
                check(wb_rd == e_rd, {e_tag, " rd"}, 64'(wb_rd), 64'(e_rd));
                check(wb_data == e_data, {e_tag, " data"}, wb_data, e_data);
                check(pc == e_pc, {e_tag, " R9 pc"}, pc, e_pc);
            end
        end
    end

    // Memory model with fixed latency.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_req_valid) begin
                logic [63:0] a, ea;
                a = mem_req_addr;
                ea = (exp_addr_q.size() != 0) ? exp_addr_q.pop_front() : 64'hDEAD;
                check(a == ea, "R3 load address", a, ea);
                repeat (MEM_LAT) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_f(a);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_data  = '0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) model_reg[i] = '0;
        model_pc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(pc == 64'd0, "R10 pc", pc, 64'd0);
        check(instr_ready == 1'b1, "R10 ready", 64'(instr_ready), 64'd1);
        check(!wb_valid && !illegal && !mem_req_valid, "R10 outputs low",
              64'({wb_valid, illegal, mem_req_valid}), 64'd0);
        issue(enc_addi(5, 3, 0), "R10 register cleared");

        // R1, R6 basic add from register 0
        issue(enc_addi(1, 0, 100), "R1 R6 add");
        issue(enc_addi(2, 1, -1), "R2 minus one");
        issue(enc_addi(3, 2, -2048), "R2 most negative");
        issue(enc_addi(4, 0, 2047), "R2 most positive");
        issue(enc_addi(9, 4, 1), "R1 chain");

        // R7 write to register 0 discarded
        issue(enc_addi(0, 1, 5), "R7 write x0");
        issue(enc_addi(10, 0, 0), "R7 x0 still zero");

        // R3 / R5 loads
        issue(enc_ld(6, 1, 16), "R5 load");
        issue(enc_ld(7, 6, -8), "R5 dependent load");
        issue(enc_ld(0, 1, 0), "R7 load into x0");
        issue(enc_addi(11, 0, 0), "R7 x0 after load");

        // R4 busy window with an intruding word
        issue(enc_ld(12, 4, -2047), "R4 load");
        check(instr_ready == 1'b0, "R4 busy", 64'(instr_ready), 64'd0);
        instr_valid = 1'b1;
        instr_word  = enc_addi(20, 0, 77);
        @(negedge clk);
        check(instr_ready == 1'b0, "R4 busy", 64'(instr_ready), 64'd0);
        @(negedge clk);
        instr_valid = 1'b0;
        issue(enc_addi(21, 20, 0), "R4 intruder ignored");

        // R8 illegal words
        issue(32'h0000_0000, "R8 zero word");
        issue(32'hFFFF_FFFF, "R8 ones word");
        issue({12'd5, 5'd1, 3'b001, 5'd13, 7'b0010011}, "R8 opimm fn3");
        issue({12'd0, 5'd1, 3'b010, 5'd13, 7'b0000011}, "R8 load fn3");
        issue({7'd0, 5'd2, 5'd1, 3'b011, 5'd0, 7'b0100011}, "R8 store");
        issue(enc_addi(14, 13, 0), "R8 regs untouched");
        issue(enc_addi(15, 1, 0), "R8 x1 intact");

        // R9 back-to-back retirements
        for (int k = 0; k < 4; k++) issue(enc_addi(16, 16, 3), "R9 step");
        issue(enc_ld(17, 16, 8), "R9 load step");

        repeat (10) @(negedge clk);
        check(exp_rd_q.size() == 0, "R5 all retired", 64'(exp_rd_q.size()), 64'd0);
        check(exp_addr_q.size() == 0, "R3 all requested", 64'(exp_addr_q.size()), 64'd0);
        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule